// File: doc/BRIEF.md
# Self-Programming Configuration Readback Unit

This unit sits between a CPU and its program memory. The CPU writes a small control byte. With the enable bit and the configuration-select bit set together, that byte opens a short read window. A program-memory read issued inside the window does not return flash data. It returns a configuration byte chosen by the read pointer: the low, high or extended fuse byte, or the lock bits. Configuration bits use inverted sense: a programmed bit reads 0 and an unprogrammed bit reads 1. Outside the window, reads pass the flash data through unchanged.

The same control byte also starts page erase, page write and lock-bit write operations. Each of these holds `busy` high for a fixed number of ticks of a separate calibrated oscillator. A programming operation cannot be aborted by the ordinary reset. Only the power-on clear stops it; otherwise it runs until its tick count is reached. The flash array, the oscillator and supply monitoring sit outside this block.

Top module: `selfprog_cfg_unit`

## Requirements
- R1: After power-on clear (`por_n` low), `busy` is 0 and a read returns `fl_rdata` unchanged.
- R2: A control write with bit 0 (enable) and bit 3 (configuration select) both set opens a window. A read in any of the `WIN_CYC` (default 3) cycles that follow the write returns a configuration byte. A read in the same cycle as the write does not.
- R3: A read made in the cycle after the window expires returns `fl_rdata`.
- R4: The window closes after one configuration read, so a second read returns `fl_rdata`.
- R5: Inside the window, the pointer selects the result. 0x0000 gives the inverted low-fuse mask and 0x0001 the inverted lock mask. 0x0002 gives 4'hF in bits 7:4 and the inverted 4-bit extended mask in bits 3:0. 0x0003 gives the inverted high-fuse mask. Any other pointer gives 0xFF. Each mask parameter holds 1 for a programmed bit.
- R6: Outside the window, `rd_data` equals `fl_rdata` for every data pattern.
- R7: A control write with bit 0 set, bit 3 clear, and at least one of bit 1 (page erase), bit 2 (page write) or bit 4 (lock write) set starts an operation. `busy` rises in the next cycle and falls in the cycle after the `PROG_TICKS`-th sampled `osc_tick`.
- R8: Operation commands issued while `busy` is high are ignored and do not extend the operation.
- R9: Asserting `rst_n` does not clear `busy` or stop the tick count. It does close an open window.
- R10: A control write without bit 0 does nothing. A write with bits 0 and 3 set, together with an operation bit, only opens the window and does not start an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on clear, active low; the only clear that stops an operation |
| rst_n | input | 1 | System reset, active low; clears the window only |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_wdata | input | 8 | Control byte: bit0 enable, bit1 erase, bit2 page write, bit3 config select, bit4 lock write |
| osc_tick | input | 1 | One-cycle pulse per calibrated-oscillator tick, already synchronized to `clk` |
| rd_en | input | 1 | Program-memory read strobe |
| rd_addr | input | AW | Read pointer |
| fl_rdata | input | 8 | Data from the flash read port |
| rd_data | output | 8 | Read result (combinational) |
| busy | output | 1 | Programming operation in progress |

## Verification
The bench reads in the first, the last and the first-expired cycle of the window. A window that is off by one would either drop a valid configuration read or leak configuration data into a normal fetch. It reads twice after a single arming and asserts reset in the middle of an operation. A unit that stays armed would keep hiding flash data, and one that clears on reset would drop `busy` early. It also sends a second erase partway through an operation and checks that `busy` still ends on the original tick. A design that restarts its count on that command would stay busy longer.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

  localparam int CB_EN     = 0;
  localparam int CB_ERASE  = 1;
  localparam int CB_PGWR   = 2;
  localparam int CB_CFGSEL = 3;
  localparam int CB_LOCKWR = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ARM  = 2'd1,
    OP_PROG = 2'd2
  } ctl_op_e;

  // Config select takes priority over any operation bit.
  function automatic ctl_op_e decode_ctl(input logic [7:0] d);
    if (!d[CB_EN])          return OP_NONE;
    else if (d[CB_CFGSEL])  return OP_ARM;
    else if (d[CB_ERASE] || d[CB_PGWR] || d[CB_LOCKWR]) return OP_PROG;
    else                    return OP_NONE;
  endfunction

  // Programmed-bit masks in, read-sense byte out.
  function automatic logic [7:0] cfg_byte(input logic       in_range,
                                          input logic [1:0] idx,
                                          input logic [7:0] low_p,
                                          input logic [7:0] lock_p,
                                          input logic [3:0] ext_p,
                                          input logic [7:0] high_p);
    if (!in_range) return 8'hFF;
    case (idx)
      2'd0:    return ~low_p;
      2'd1:    return ~lock_p;
      2'd2:    return {4'hF, ~ext_p};
      default: return ~high_p;
    endcase
  endfunction

endpackage

// File: rtl/cfg_window.sv
module cfg_window #(
  parameter int WIN_CYC = 3
) (
  input  logic clk,
  input  logic clr_n,
  input  logic arm_evt,
  input  logic cfg_hit,
  output logic win_open
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!clr_n)             left_q <= '0;
    else if (arm_evt)       left_q <= CW'(WIN_CYC);
    else if (cfg_hit)       left_q <= '0;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign win_open = (left_q != '0);
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_TICKS = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start_evt,
  input  logic osc_tick,
  output logic busy,
  output logic done_evt
);
  localparam int TW = $clog2(PROG_TICKS + 1);

  logic [TW-1:0] ticks_q;
  logic          busy_q;

  assign done_evt = busy_q && osc_tick && (ticks_q == TW'(PROG_TICKS - 1));

  // Only power-on clear touches this state; system reset does not.
  always_ff @(posedge clk) begin
    if (!por_n) begin
      busy_q  <= 1'b0;
      ticks_q <= '0;
    end else if (start_evt) begin
      busy_q  <= 1'b1;
      ticks_q <= '0;
    end else if (done_evt) begin
      busy_q  <= 1'b0;
      ticks_q <= '0;
    end else if (busy_q && osc_tick) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import selfprog_pkg::*;
#(
  parameter int         AW        = 16,
  parameter logic [7:0] LOW_PROG  = 8'h00,
  parameter logic [7:0] LOCK_PROG = 8'h00,
  parameter logic [3:0] EXT_PROG  = 4'h0,
  parameter logic [7:0] HIGH_PROG = 8'h00
) (
  input  logic          cfg_hit,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    fl_rdata,
  output logic [7:0]    rd_data
);
  logic in_range;
  assign in_range = (rd_addr >> 2) == '0;

  always_comb begin
    if (cfg_hit)
      rd_data = cfg_byte(in_range, rd_addr[1:0], LOW_PROG, LOCK_PROG, EXT_PROG, HIGH_PROG);
    else
      rd_data = fl_rdata;
  end
endmodule

// File: rtl/selfprog_cfg_unit.sv
module selfprog_cfg_unit
  import selfprog_pkg::*;
#(
  parameter int         AW         = 16,
  parameter int         WIN_CYC    = 3,
  parameter int         PROG_TICKS = 16,
  parameter logic [7:0] LOW_PROG   = 8'h62,
  parameter logic [7:0] LOCK_PROG  = 8'h0C,
  parameter logic [3:0] EXT_PROG   = 4'h5,
  parameter logic [7:0] HIGH_PROG  = 8'h99
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  input  logic          osc_tick,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    fl_rdata,
  output logic [7:0]    rd_data,
  output logic          busy
);
  ctl_op_e op;
  logic    cmd_ok, arm_evt, start_evt, done_evt, win_open, cfg_hit, win_clr_n;

  assign op        = decode_ctl(ctl_wdata);
  assign cmd_ok    = ctl_wr && rst_n && por_n;
  assign arm_evt   = cmd_ok && (op == OP_ARM);
  assign start_evt = cmd_ok && (op == OP_PROG) && !busy;
  assign cfg_hit   = rd_en && win_open;
  assign win_clr_n = rst_n && por_n;

  cfg_window #(.WIN_CYC(WIN_CYC)) win_i (
    .clk(clk), .clr_n(win_clr_n), .arm_evt(arm_evt),
    .cfg_hit(cfg_hit), .win_open(win_open)
  );

  prog_timer #(.PROG_TICKS(PROG_TICKS)) tmr_i (
    .clk(clk), .por_n(por_n), .start_evt(start_evt),
    .osc_tick(osc_tick), .busy(busy), .done_evt(done_evt)
  );

  cfg_read_mux #(
    .AW(AW), .LOW_PROG(LOW_PROG), .LOCK_PROG(LOCK_PROG),
    .EXT_PROG(EXT_PROG), .HIGH_PROG(HIGH_PROG)
  ) mux_i (
    .cfg_hit(cfg_hit), .rd_addr(rd_addr), .fl_rdata(fl_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/selfprog_cfg_chk.sv
module selfprog_cfg_chk #(
  parameter int WIN_CYC = 3
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       osc_tick,
  input logic [7:0] rd_data,
  input logic [7:0] fl_rdata,
  input logic       busy,
  input logic       win_open,
  input logic       cfg_hit,
  input logic       start_evt,
  input logic       done_evt,
  input logic       arm_evt
);
  localparam int CW = $clog2(WIN_CYC + 2);
  logic [CW-1:0] open_run;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n || arm_evt) open_run <= '0;
    else if (win_open)               open_run <= open_run + 1'b1;
    else                             open_run <= '0;
  end

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    win_open |-> (open_run < CW'(WIN_CYC)));

  // R4
  one_shot_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cfg_hit && !arm_evt) |=> !win_open);

  // R6
  pass_thru_chk: assert property (@(posedge clk) disable iff (!por_n)
    !win_open |-> (rd_data == fl_rdata));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(busy) |-> $past(start_evt));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(busy) |-> $past(osc_tick));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !done_evt) |=> busy);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !start_evt);
endmodule

bind selfprog_cfg_unit selfprog_cfg_chk #(.WIN_CYC(WIN_CYC)) chk_i (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .osc_tick(osc_tick),
  .rd_data(rd_data), .fl_rdata(fl_rdata), .busy(busy), .win_open(win_open),
  .cfg_hit(cfg_hit), .start_evt(start_evt), .done_evt(done_evt), .arm_evt(arm_evt)
);

// File: tb/selfprog_cfg_unit_tb_top.sv
`timescale 1ns/1ps
module selfprog_cfg_unit_tb_top;
  localparam int AW = 16;
  localparam int TK = 5;
  localparam logic [7:0] LOWP = 8'h62, LOCKP = 8'h0C, HIGHP = 8'h99;
  localparam logic [3:0] EXTP = 4'h5;

  logic clk = 1'b0;
  logic por_n, rst_n, ctl_wr, osc_tick, rd_en;
  logic [7:0] ctl_wdata, fl_rdata, rd_data;
  logic [AW-1:0] rd_addr;
  logic busy;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  selfprog_cfg_unit #(.AW(AW), .WIN_CYC(3), .PROG_TICKS(TK), .LOW_PROG(LOWP),
    .LOCK_PROG(LOCKP), .EXT_PROG(EXTP), .HIGH_PROG(HIGHP)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .osc_tick(osc_tick), .rd_en(rd_en), .rd_addr(rd_addr), .fl_rdata(fl_rdata),
    .rd_data(rd_data), .busy(busy));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected configuration byte, written from the pointer map.
  function automatic logic [7:0] exp_cfg(input logic [AW-1:0] a);
    logic [7:0] r;
    r = 8'hFF;
    if (a == 16'h0000) r = LOWP ^ 8'hFF;
    if (a == 16'h0001) r = LOCKP ^ 8'hFF;
    if (a == 16'h0002) r = {4'b1111, EXTP ^ 4'hF};
    if (a == 16'h0003) r = HIGHP ^ 8'hFF;
    return r;
  endfunction

  // Write the control byte; returns at the negedge after the write edge.
  task automatic ctl_write(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  // Read at the current negedge; strobe is consumed by the next edge.
  task automatic rd_now(input logic [AW-1:0] a, input logic [7:0] fd, output logic [7:0] q);
    rd_en = 1'b1; rd_addr = a; fl_rdata = fd;
    #1 q = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic t_reset_state;
    logic [7:0] q;
    chk("R1 busy after por", {7'd0, busy}, 8'h00);
    rd_now(16'h0002, 8'h3C, q);
    chk("R1 read after por", q, 8'h3C);
  endtask

  task automatic t_window_cycles;
    logic [7:0] q;
    ctl_write(8'h09); rd_now(16'h0000, 8'h11, q);           // cycle 1
    chk("R2 window cycle1", q, exp_cfg(16'h0000));
    ctl_write(8'h09); @(negedge clk); @(negedge clk);
    rd_now(16'h0003, 8'h22, q);                             // cycle 3
    chk("R2 window cycle3", q, exp_cfg(16'h0003));
    ctl_write(8'h09); repeat (3) @(negedge clk);
    rd_now(16'h0002, 8'h33, q);                             // cycle 4
    chk("R3 window expired", q, 8'h33);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 8'h09;
    rd_en = 1'b1; rd_addr = 16'h0001; fl_rdata = 8'h44;
    #1 chk("R2 same-cycle read", rd_data, 8'h44);
    @(negedge clk); ctl_wr = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_one_shot;
    logic [7:0] q;
    ctl_write(8'h09); rd_now(16'h0001, 8'h55, q);
    chk("R4 first read", q, exp_cfg(16'h0001));
    rd_now(16'h0001, 8'h56, q);
    chk("R4 second read", q, 8'h56);
  endtask

  task automatic t_pointer_map;
    logic [7:0] q;
    logic [AW-1:0] ptrs[6] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'hFFFF};
    for (int i = 0; i < 6; i++) begin
      ctl_write(8'h09); rd_now(ptrs[i], 8'h00, q);
      chk($sformatf("R5 ptr %h", ptrs[i]), q, exp_cfg(ptrs[i]));
    end
  endtask

  task automatic t_pass_thru;
    logic [7:0] q;
    logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    for (int i = 0; i < 4; i++) begin
      rd_now(16'h0002, pats[i], q);
      chk("R6 pass-through", q, pats[i]);
    end
  endtask

  task automatic t_prog_ops;
    logic [7:0] cmds[3] = '{8'h03, 8'h05, 8'h11};
    for (int i = 0; i < 3; i++) begin
      ctl_write(cmds[i]);
      chk("R7 busy rises", {7'd0, busy}, 8'h01);
      ticks(TK - 1);
      chk("R7 busy before last tick", {7'd0, busy}, 8'h01);
      ticks(1);
      chk("R7 busy after last tick", {7'd0, busy}, 8'h00);
    end
  endtask

  task automatic t_ignore_busy;
    ctl_write(8'h03); ticks(2);
    ctl_write(8'h05); ticks(TK - 3);
    chk("R8 still busy", {7'd0, busy}, 8'h01);
    ticks(1);
    chk("R8 ends on original count", {7'd0, busy}, 8'h00);
  endtask

  task automatic t_reset_through;
    logic [7:0] q;
    ctl_write(8'h05); ticks(2);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 busy held in reset", {7'd0, busy}, 8'h01);
    rst_n = 1'b1;
    ticks(TK - 2);
    chk("R9 busy ends after reset", {7'd0, busy}, 8'h00);
    ctl_write(8'h09);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_now(16'h0000, 8'h77, q);
    chk("R9 reset closes window", q, 8'h77);
  endtask

  task automatic t_no_enable;
    logic [7:0] q;
    ctl_write(8'h1E);
    chk("R10 no enable, no busy", {7'd0, busy}, 8'h00);
    rd_now(16'h0000, 8'h88, q);
    chk("R10 no enable, no window", q, 8'h88);
    ctl_write(8'h0B);
    chk("R10 config select wins", {7'd0, busy}, 8'h00);
    rd_now(16'h0003, 8'h99, q);
    chk("R10 window opened", q, exp_cfg(16'h0003));
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00;
    osc_tick = 1'b0; rd_en = 1'b0; rd_addr = '0; fl_rdata = 8'h00;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_window_cycles();
    t_one_shot();
    t_pointer_map();
    t_pass_thru();
    t_prog_ops();
    t_ignore_busy();
    t_reset_through();
    t_no_enable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule